// File: doc/BRIEF.md
# Power-Down Wake-Up Sequencer

This block takes a processor out of a software-entered power-down state when an active-low external interrupt pin is pulled low. A pin wake-up is allowed only if the wake enable was set when power-down was entered. The pin must then stay low for a minimum time, counted in ticks of a free-running slow timebase. After that, the block starts both oscillators and waits until the oscillator-stable input reports that the main clock has reached its nominal frequency. It then raises a dedicated wake-up interrupt request at vector 0x007B.

From the start of the low-time qualification until the wake-up routine returns, the block masks all interrupt requests. The peripheral freeze (timers, synchronous serial unit, CAN unit, watchdog) stays asserted from power-down entry until that same return. If the pin is still low when the routine returns and the external-interrupt enable is set, the block forwards one ordinary external interrupt request as the mask lifts.

Top module: `pd_wake_seq`

## Requirements
- R1: A synchronous reset (`rst` high) puts the block in its run state with every output at 0, including `wake_vec`.
- R2: In the run state, a `pd_req` pulse enters power-down and asserts `periph_freeze` in the next cycle. The block samples `wake_en` at that moment as its arm bit.
- R3: If the arm bit is 0, the pin and ticks have no effect during power-down: the oscillator starts and `irq_block` stay 0, and `periph_freeze` stays 1. Setting `wake_en` after entry changes nothing.
- R4: Once armed, a low level on `int_pin` is seen through a two-flop synchronizer and starts qualification, which asserts `irq_block`. Wake-up needs `LOW_TICKS` (default 4) `tick` pulses while the pin stays low. If the pin returns high first, the block goes back to power-down and the count restarts from zero.
- R5: When qualification completes, `rc_osc_start` and `main_osc_start` go to 1 and `pin_held_low` goes to 1. The block holds this state, ignoring the pin and ticks, until `osc_stable` is 1.
- R6: The cycle after `osc_stable` is seen, the start enables drop, `wake_irq` goes to 1 and `wake_vec` reads 0x007B. At all other times `wake_vec` is 0.
- R7: `wake_irq` stays at 1 until `irq_ack` is sampled high, and is 0 from the next cycle.
- R8: `irq_block` stays at 1 from qualification until the cycle after a `reti` pulse in the wake-up phase, and is 0 from then on.
- R9: `periph_freeze` stays at 1 from power-down entry until the cycle after that `reti`.
- R10: If at that `reti` the synchronized pin is low and `ext0_en` is 1, `ext0_irq` is 1 for exactly the one cycle after `reti`. Otherwise it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pd_req | input | 1 | Power-down entry pulse from software |
| wake_en | input | 1 | Pin wake-up enable, sampled at entry |
| int_pin | input | 1 | External interrupt pin level, active low |
| tick | input | 1 | One-cycle pulse from the slow timebase |
| osc_stable | input | 1 | Main oscillator reported at nominal frequency |
| irq_ack | input | 1 | CPU acknowledge of the wake-up request |
| reti | input | 1 | Return-from-interrupt pulse |
| ext0_en | input | 1 | External interrupt 0 enable bit |
| rc_osc_start | output | 1 | Start enable for the internal RC oscillator |
| main_osc_start | output | 1 | Start enable for the main oscillator |
| wake_irq | output | 1 | Wake-up interrupt request |
| wake_vec | output | 16 | Vector of the pending wake-up request |
| irq_block | output | 1 | Global interrupt mask |
| periph_freeze | output | 1 | Peripheral freeze |
| pin_held_low | output | 1 | Latched pin state: the qualified low level |
| ext0_irq | output | 1 | Forwarded external interrupt 0 request |

## Verification
A pin change reaches the state after three rising edges: two synchronizer flops and then the state register. So `irq_block` is checked on the third falling edge after the pin is driven low. The last qualifying tick, `osc_stable`, `irq_ack` and `reti` each act at the first rising edge, so their results are checked on the next falling edge. The `ext0_irq` pulse is checked both in that cycle and in the cycle after, to show it lasts one cycle. All inputs change on falling edges and all outputs are sampled on falling edges. Each check therefore lands between the edge that produces a result and the edge that could change it.

// File: rtl/pd_wake_seq.sv
module pd_wake_seq #(
  parameter int          LOW_TICKS   = 4,
  parameter logic [15:0] WAKE_VECTOR = 16'h007B
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pd_req,
  input  logic        wake_en,
  input  logic        int_pin,
  input  logic        tick,
  input  logic        osc_stable,
  input  logic        irq_ack,
  input  logic        reti,
  input  logic        ext0_en,
  output logic        rc_osc_start,
  output logic        main_osc_start,
  output logic        wake_irq,
  output logic [15:0] wake_vec,
  output logic        irq_block,
  output logic        periph_freeze,
  output logic        pin_held_low,
  output logic        ext0_irq
);

  localparam int CW = (LOW_TICKS < 2) ? 1 : $clog2(LOW_TICKS);

  typedef enum logic [2:0] {S_RUN, S_PDOWN, S_LATCH, S_STARTUP, S_WAKE} state_t;

  state_t        st;
  logic [1:0]    pin_sync;
  logic [CW-1:0] cnt;
  logic          armed, irq_q, latched, ext0_q;

  wire pin_hi = pin_sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_RUN;
      pin_sync <= 2'b11;
      cnt      <= '0;
      armed    <= 1'b0;
      irq_q    <= 1'b0;
      latched  <= 1'b0;
      ext0_q   <= 1'b0;
    end else begin
      pin_sync <= {pin_sync[0], int_pin};
      ext0_q   <= 1'b0;
      case (st)
        S_RUN: if (pd_req) begin
          st    <= S_PDOWN;
          armed <= wake_en;
        end
        S_PDOWN: begin
          cnt <= '0;
          if (armed && !pin_hi) st <= S_LATCH;
        end
        S_LATCH: begin
          if (pin_hi) begin
            st  <= S_PDOWN;
            cnt <= '0;
          end else if (tick) begin
            if (cnt == CW'(LOW_TICKS - 1)) begin
              st      <= S_STARTUP;
              latched <= ~pin_hi;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        S_STARTUP: if (osc_stable) begin
          st    <= S_WAKE;
          irq_q <= 1'b1;
        end
        S_WAKE: begin
          if (irq_ack) irq_q <= 1'b0;
          if (reti) begin
            st      <= S_RUN;
            irq_q   <= 1'b0;
            latched <= 1'b0;
            ext0_q  <= ext0_en & ~pin_hi;
          end
        end
        default: st <= S_RUN;
      endcase
    end
  end

  assign rc_osc_start   = (st == S_STARTUP);
  assign main_osc_start = (st == S_STARTUP);
  assign wake_irq       = irq_q;
  assign wake_vec       = irq_q ? WAKE_VECTOR : 16'h0000;
  assign irq_block      = (st == S_LATCH) || (st == S_STARTUP) || (st == S_WAKE);
  assign periph_freeze  = (st != S_RUN);
  assign pin_held_low   = latched;
  assign ext0_irq       = ext0_q;

  assert_unarmed_stays_R3: assert property (@(posedge clk) disable iff (rst)
    (st == S_PDOWN && !armed) |=> (st == S_PDOWN));

  assert_osc_after_qualify_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rc_osc_start) |-> ($past(st) == S_LATCH && $past(tick)));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    wake_irq |-> irq_block);

  assert_ack_drops_R7: assert property (@(posedge clk) disable iff (rst)
    (wake_irq && irq_ack && !reti) |=> !wake_irq);

  assert_freeze_release_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(periph_freeze) |-> $past(reti));

  assert_ext0_unmasked_R10: assert property (@(posedge clk) disable iff (rst)
    ext0_irq |-> (!irq_block && $past(reti) && $past(ext0_en)));

endmodule

// File: tb/pd_wake_seq_test.sv
`timescale 1ns/1ps
module pd_wake_seq_test;
  localparam int LT = 4;

  logic clk = 0, rst = 1;
  logic pd_req = 0, wake_en = 0, int_pin = 1, tick = 0, osc_stable = 0;
  logic irq_ack = 0, reti = 0, ext0_en = 0;
  logic rc_osc_start, main_osc_start, wake_irq, irq_block, periph_freeze, pin_held_low, ext0_irq;
  logic [15:0] wake_vec;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pd_wake_seq #(.LOW_TICKS(LT)) uut (
    .clk(clk), .rst(rst), .pd_req(pd_req), .wake_en(wake_en), .int_pin(int_pin),
    .tick(tick), .osc_stable(osc_stable), .irq_ack(irq_ack), .reti(reti),
    .ext0_en(ext0_en), .rc_osc_start(rc_osc_start), .main_osc_start(main_osc_start),
    .wake_irq(wake_irq), .wake_vec(wake_vec), .irq_block(irq_block),
    .periph_freeze(periph_freeze), .pin_held_low(pin_held_low), .ext0_irq(ext0_irq));

  task automatic check(input int act, input int exp, input string msg);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1; pd_req = 0; wake_en = 0; int_pin = 1; tick = 0; osc_stable = 0;
    irq_ack = 0; reti = 0; ext0_en = 0;
    cyc(2);
    rst = 0;
    cyc(1);
  endtask

  task automatic enter_pd(input logic en);
    wake_en = en; pd_req = 1;
    cyc(1);
    pd_req = 0;
    cyc(1);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; cyc(1); tick = 0; cyc(1);
    end
  endtask

  task automatic pin_low_to_latch;
    int_pin = 0;
    cyc(3);
  endtask

  task automatic reach_routine;
    do_reset;
    enter_pd(1);
    pin_low_to_latch;
    ticks(LT);
    osc_stable = 1; cyc(1); osc_stable = 0;
    irq_ack = 1; cyc(1); irq_ack = 0;
  endtask

  // {low ticks, wake expected}
  localparam int NV = 5;
  localparam int VEC [NV][2] = '{'{0, 0}, '{1, 0}, '{LT-1, 0}, '{LT, 1}, '{LT+3, 1}};

  initial begin
    #2000000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset;
    check(rc_osc_start | main_osc_start | wake_irq | irq_block, 0, "R1 reset outputs");
    check(periph_freeze | pin_held_low | ext0_irq, 0, "R1 reset outputs");
    check(wake_vec, 0, "R1 reset vector");

    for (int v = 0; v < NV; v++) begin
      do_reset;
      enter_pd(1);
      check(periph_freeze, 1, "R2 freeze on entry");
      pin_low_to_latch;
      check(irq_block, 1, "R4 qualification masks");
      ticks(VEC[v][0]);
      int_pin = 1;
      cyc(4);
      check(rc_osc_start, VEC[v][1], "R4 pulse length rc start");
      check(main_osc_start, VEC[v][1], "R5 main start");
      check(pin_held_low, VEC[v][1], "R5 pin latched");
      check(irq_block, VEC[v][1], "R8 mask per result");
      check(periph_freeze, 1, "R9 freeze held");
    end

    // R3: not armed at entry
    do_reset;
    enter_pd(0);
    wake_en = 1;
    int_pin = 0;
    cyc(3);
    ticks(LT * 3);
    check(irq_block, 0, "R3 unarmed no mask");
    check(rc_osc_start, 0, "R3 unarmed no start");
    check(periph_freeze, 1, "R3 still powered down");

    // R4: counter restart after early release
    do_reset;
    enter_pd(1);
    pin_low_to_latch;
    ticks(LT - 1);
    int_pin = 1; cyc(4);
    check(irq_block, 0, "R4 back to power-down");
    pin_low_to_latch;
    ticks(LT - 1);
    check(rc_osc_start, 0, "R4 count restarted");
    tick = 1; cyc(1); tick = 0;
    check(rc_osc_start, 1, "R4 exact minimum wakes");

    // R5: pin and ticks ignored in start-up
    int_pin = 1; cyc(4); ticks(3); int_pin = 0; cyc(4);
    check(rc_osc_start, 1, "R5 waits for stable");
    check(pin_held_low, 1, "R5 latch ignores pin");
    check(wake_irq, 0, "R5 no request yet");

    // R6
    osc_stable = 1; cyc(1); osc_stable = 0;
    check(wake_irq, 1, "R6 wake request");
    check(wake_vec, 16'h007B, "R6 vector");
    check(rc_osc_start, 0, "R6 start enable drops");

    // R7
    cyc(5);
    check(wake_irq, 1, "R7 held until ack");
    irq_ack = 1; cyc(1); irq_ack = 0;
    check(wake_irq, 0, "R7 drops after ack");
    check(wake_vec, 0, "R6 vector cleared");
    check(irq_block, 1, "R8 mask held until return");

    // R8 R9 R10: return with pin low and enable set
    ext0_en = 1;
    cyc(3);
    check(periph_freeze, 1, "R9 freeze before return");
    reti = 1; cyc(1); reti = 0;
    check(irq_block, 0, "R8 mask released");
    check(periph_freeze, 0, "R9 freeze released");
    check(ext0_irq, 1, "R10 forwarded request");
    cyc(1);
    check(ext0_irq, 0, "R10 one-cycle request");

    // R10: enable clear
    reach_routine;
    ext0_en = 0; cyc(3);
    reti = 1; cyc(1); reti = 0;
    check(ext0_irq, 0, "R10 no forward without enable");
    check(irq_block, 0, "R8 release without forward");

    // R10: pin high at return
    reach_routine;
    int_pin = 1; ext0_en = 1; cyc(3);
    reti = 1; cyc(1); reti = 0;
    check(ext0_irq, 0, "R10 no forward with pin high");
    check(periph_freeze, 0, "R9 release with pin high");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule